// File: doc/BRIEF.md
# Polled and Interrupting Terminal Register Block

This peripheral sits on a processor's load/store bus and gives software a keyboard input channel and a display output channel. Four word-wide registers appear in a reserved window at the top of the address space. The registers are a control word and a data word for each direction. Software can poll a ready flag in each control word. It can also set a per-direction enable so that the block raises an interrupt level while that direction is ready.

On the device side, a keyboard source delivers one byte with a one-cycle valid strobe. The display side receives a byte with a valid level and hands it back by pulsing an acknowledge. Reading the keyboard data word consumes the character. Writing the display data word starts a transfer. Both actions change the ready flags one clock later. Read data is combinational from the addressed register while the read strobe is high, so a load completes in the cycle it is issued.

Top module: `mmio_terminal`

## Requirements
- R1: After reset, keyboard ready is 0, display ready is 1, both enables are 0, both data words read 0, `irq` is 0 and `disp_valid` is 0.
- R2: The address map is keyboard control at 0xFFFF0000, keyboard data at 0xFFFF0004, display control at 0xFFFF0008 and display data at 0xFFFF000C. In each control word, bit 0 is ready, bit 1 is interrupt enable, and all other bits read 0.
- R3: A `kbd_valid` strobe captures `kbd_char` and sets keyboard ready on the next edge. A read of keyboard data returns that character in bits 7:0, with bits 31:8 zero.
- R4: A read of keyboard data with no byte arriving in the same cycle clears keyboard ready at the next edge.
- R5: A byte that arrives while keyboard ready is 1 overwrites the data word and leaves ready at 1. If a byte arrives in the same cycle as a data read, that read returns the old character and ready stays at 1.
- R6: A write to display data while display ready is 1 latches bits 7:0 onto `disp_char`, raises `disp_valid` and clears display ready. Reading display data returns the last latched character in bits 7:0.
- R7: A write to display data while display ready is 0 is ignored, and `disp_char` keeps its value.
- R8: `disp_ack` while `disp_valid` is 1 sets display ready and drops `disp_valid` at the next edge.
- R9: A control write loads bit 1 into the enable. Bit 0 of the write is ignored, so ready cannot be changed by software.
- R10: `irq` is 1 exactly while (keyboard ready AND keyboard enable) OR (display ready AND display enable) holds, and it stays high until that condition clears.
- R11: Unmapped or misaligned offsets inside the window, and any address outside it, read 0. Writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 32 | Byte address of the access |
| bus_re | input | 1 | Read strobe |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when not reading |
| kbd_valid | input | 1 | One-cycle strobe for an arriving keyboard byte |
| kbd_char | input | 8 | Arriving keyboard byte |
| disp_valid | output | 1 | Display byte pending |
| disp_char | output | 8 | Display byte |
| disp_ack | input | 1 | Display has taken the pending byte |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest situation to reach is a keyboard byte arriving in the same cycle as the load that would consume the previous one. In that cycle the clear and the set compete. The stimulus drives the read strobe and `kbd_valid` on the same falling edge, then confirms three things: the old character comes back, ready remains set, and the new character is what the next read returns. A second hard case is a display write issued while a transfer is still pending. The stimulus holds off the acknowledge so that it can show the second write leaves `disp_char` untouched.

// File: rtl/term_pkg.sv
package term_pkg;
    localparam int unsigned OFF_KBD_CTL  = 32'h0;
    localparam int unsigned OFF_KBD_DATA = 32'h4;
    localparam int unsigned OFF_DSP_CTL  = 32'h8;
    localparam int unsigned OFF_DSP_DATA = 32'hC;
    localparam int unsigned BIT_READY    = 0;
    localparam int unsigned BIT_ENABLE   = 1;
endpackage

// File: rtl/term_addr_decode.sv
module term_addr_decode #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned WIN_W  = 16,
    parameter logic [ADDR_W-1:0] BASE = 32'hFFFF0000
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              kbd_ctl_sel,
    output logic              kbd_dat_sel,
    output logic              dsp_ctl_sel,
    output logic              dsp_dat_sel
);
    import term_pkg::*;

    logic             in_window;
    logic [WIN_W-1:0] offset;

    always_comb begin
        in_window   = (addr[ADDR_W-1:WIN_W] == BASE[ADDR_W-1:WIN_W]);
        offset      = addr[WIN_W-1:0];
        kbd_ctl_sel = in_window && (offset == WIN_W'(OFF_KBD_CTL));
        kbd_dat_sel = in_window && (offset == WIN_W'(OFF_KBD_DATA));
        dsp_ctl_sel = in_window && (offset == WIN_W'(OFF_DSP_CTL));
        dsp_dat_sel = in_window && (offset == WIN_W'(OFF_DSP_DATA));
    end
endmodule

// File: rtl/term_rx_chan.sv
module term_rx_chan #(
    parameter int unsigned CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic              ie_wval,
    input  logic              data_rd,
    input  logic              in_valid,
    input  logic [CHAR_W-1:0] in_char,
    output logic              ready,
    output logic              ie,
    output logic [CHAR_W-1:0] data
);
    typedef struct packed {
        logic              ready;
        logic              ie;
        logic [CHAR_W-1:0] data;
    } rx_state_t;

    rx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctl_wr)   st_d.ie    = ie_wval;
        if (data_rd)  st_d.ready = 1'b0;
        if (in_valid) begin
            st_d.ready = 1'b1;
            st_d.data  = in_char;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ready = st_q.ready;
    assign ie    = st_q.ie;
    assign data  = st_q.data;

    // R3
    rx_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (ready && data == $past(in_char)));

    // R4
    rx_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !in_valid) |=> !ready);

    // R5
    rx_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && in_valid) |=> ready);
endmodule

// File: rtl/term_tx_chan.sv
module term_tx_chan #(
    parameter int unsigned CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic              ie_wval,
    input  logic              data_wr,
    input  logic [CHAR_W-1:0] wchar,
    input  logic              ack,
    output logic              ready,
    output logic              ie,
    output logic [CHAR_W-1:0] data,
    output logic              out_valid
);
    typedef struct packed {
        logic              ready;
        logic              ie;
        logic [CHAR_W-1:0] data;
    } tx_state_t;

    tx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctl_wr) st_d.ie = ie_wval;
        if (ack && !st_q.ready) st_d.ready = 1'b1;
        if (data_wr && st_q.ready) begin
            st_d.data  = wchar;
            st_d.ready = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{ready: 1'b1, ie: 1'b0, data: '0};
        else        st_q <= st_d;
    end

    assign ready     = st_q.ready;
    assign ie        = st_q.ie;
    assign data      = st_q.data;
    assign out_valid = !st_q.ready;

    // R6
    tx_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && ready) |=> (!ready && data == $past(wchar)));

    // R7
    tx_busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !ready) |=> $stable(data));

    // R8
    tx_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !ready) |=> ready);
endmodule

// File: rtl/mmio_terminal.sv
module mmio_terminal #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CHAR_W = 8,
    parameter int unsigned WIN_W  = 16,
    parameter logic [ADDR_W-1:0] BASE = 32'hFFFF0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_re,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              kbd_valid,
    input  logic [CHAR_W-1:0] kbd_char,
    output logic              disp_valid,
    output logic [CHAR_W-1:0] disp_char,
    input  logic              disp_ack,
    output logic              irq
);
    import term_pkg::*;

    logic kbd_ctl_sel, kbd_dat_sel, dsp_ctl_sel, dsp_dat_sel;
    logic kbd_ready, kbd_ie, dsp_ready, dsp_ie;
    logic [CHAR_W-1:0] kbd_data, dsp_data;

    term_addr_decode #(.ADDR_W(ADDR_W), .WIN_W(WIN_W), .BASE(BASE)) u_dec (
        .addr        (bus_addr),
        .kbd_ctl_sel (kbd_ctl_sel),
        .kbd_dat_sel (kbd_dat_sel),
        .dsp_ctl_sel (dsp_ctl_sel),
        .dsp_dat_sel (dsp_dat_sel)
    );

    term_rx_chan #(.CHAR_W(CHAR_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_wr   (bus_we && kbd_ctl_sel),
        .ie_wval  (bus_wdata[BIT_ENABLE]),
        .data_rd  (bus_re && kbd_dat_sel),
        .in_valid (kbd_valid),
        .in_char  (kbd_char),
        .ready    (kbd_ready),
        .ie       (kbd_ie),
        .data     (kbd_data)
    );

    term_tx_chan #(.CHAR_W(CHAR_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (bus_we && dsp_ctl_sel),
        .ie_wval   (bus_wdata[BIT_ENABLE]),
        .data_wr   (bus_we && dsp_dat_sel),
        .wchar     (bus_wdata[CHAR_W-1:0]),
        .ack       (disp_ack),
        .ready     (dsp_ready),
        .ie        (dsp_ie),
        .data      (dsp_data),
        .out_valid (disp_valid)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_re) begin
            if (kbd_ctl_sel) begin
                bus_rdata[BIT_READY]  = kbd_ready;
                bus_rdata[BIT_ENABLE] = kbd_ie;
            end
            if (dsp_ctl_sel) begin
                bus_rdata[BIT_READY]  = dsp_ready;
                bus_rdata[BIT_ENABLE] = dsp_ie;
            end
            if (kbd_dat_sel) bus_rdata[CHAR_W-1:0] = kbd_data;
            if (dsp_dat_sel) bus_rdata[CHAR_W-1:0] = dsp_data;
        end
    end

    assign disp_char = dsp_data;
    assign irq       = (kbd_ready && kbd_ie) || (dsp_ready && dsp_ie);

    // R3
    rx_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && kbd_dat_sel) |-> (bus_rdata[DATA_W-1:CHAR_W] == '0));

    // R11
    idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |-> (bus_rdata == '0));

    // R10
    irq_on_kbd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kbd_valid && kbd_ie && !(bus_we && kbd_ctl_sel)) |=> irq);
endmodule

// File: tb/sim_mmio_terminal.sv
module sim_mmio_terminal;
    localparam int CLK_NS = 8;
    localparam logic [31:0] BASE = 32'hFFFF0000;
    localparam logic [3:0] OP_RD = 4'd0, OP_WR = 4'd1, OP_KB = 4'd2, OP_ACK = 4'd3;
    localparam int NVEC = 19;
    // {req[3:0], op[3:0], offset[15:0], data[31:0], expected[31:0]}
    localparam logic [87:0] VEC [NVEC] = '{
        {4'd1,  OP_RD,  16'h0000, 32'h0, 32'h0},          // R1
        {4'd1,  OP_RD,  16'h0004, 32'h0, 32'h0},          // R1
        {4'd1,  OP_RD,  16'h0008, 32'h0, 32'h1},          // R1
        {4'd1,  OP_RD,  16'h000C, 32'h0, 32'h0},          // R1
        {4'd3,  OP_KB,  16'h0000, 32'h41, 32'h0},         // R3
        {4'd3,  OP_RD,  16'h0000, 32'h0, 32'h1},          // R3
        {4'd3,  OP_RD,  16'h0004, 32'h0, 32'h41},         // R3
        {4'd4,  OP_RD,  16'h0000, 32'h0, 32'h0},          // R4
        {4'd9,  OP_WR,  16'h0008, 32'h3, 32'h0},          // R9
        {4'd9,  OP_RD,  16'h0008, 32'h0, 32'h3},          // R9
        {4'd2,  OP_WR,  16'h0000, 32'hFFFFFFFF, 32'h0},   // R2
        {4'd2,  OP_RD,  16'h0000, 32'h0, 32'h2},          // R2
        {4'd6,  OP_WR,  16'h000C, 32'h1234565A, 32'h0},   // R6
        {4'd6,  OP_RD,  16'h0008, 32'h0, 32'h2},          // R6
        {4'd6,  OP_RD,  16'h000C, 32'h0, 32'h5A},         // R6
        {4'd8,  OP_ACK, 16'h0000, 32'h0, 32'h0},          // R8
        {4'd8,  OP_RD,  16'h0008, 32'h0, 32'h3},          // R8
        {4'd11, OP_RD,  16'h0010, 32'h0, 32'h0},          // R11
        {4'd11, OP_RD,  16'h0002, 32'h0, 32'h0}           // R11
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_re = 1'b0, bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        kbd_valid = 1'b0;
    logic [7:0]  kbd_char = '0;
    logic        disp_valid;
    logic [7:0]  disp_char;
    logic        disp_ack = 1'b0;
    logic        irq;
    int          n_chk = 0, n_bad = 0;

    always #(CLK_NS/2) clk = ~clk;

    mmio_terminal u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_re(bus_re),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .kbd_valid(kbd_valid), .kbd_char(kbd_char), .disp_valid(disp_valid),
        .disp_char(disp_char), .disp_ack(disp_ack), .irq(irq)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [31:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        #1 check(bus_rdata, exp, tag);
        @(posedge clk); #1 bus_re = 1'b0;
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); #1 bus_we = 1'b0;
    endtask

    task automatic kb(input logic [7:0] c);
        @(negedge clk);
        kbd_char = c; kbd_valid = 1'b1;
        @(posedge clk); #1 kbd_valid = 1'b0;
    endtask

    task automatic ack();
        @(negedge clk);
        disp_ack = 1'b1;
        @(posedge clk); #1 disp_ack = 1'b0;
    endtask

    initial begin
        #(CLK_NS * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: output reset state
        check({31'b0, irq}, 32'h0, "R1 irq");
        check({31'b0, disp_valid}, 32'h0, "R1 disp_valid");

        for (int i = 0; i < NVEC; i++) begin
            logic [87:0] v;
            string tag;
            v = VEC[i];
            tag = $sformatf("R%0d vector %0d", v[87:84], i);
            case (v[83:80])
                OP_RD:   rd(BASE | {16'h0, v[79:64]}, v[31:0], tag);
                OP_WR:   wr(BASE | {16'h0, v[79:64]}, v[63:32]);
                OP_KB:   kb(v[39:32]);
                default: ack();
            endcase
        end

        // R10: display ready with enable drives irq
        check({31'b0, irq}, 32'h1, "R10 tx ready+ie");
        wr(BASE | 32'h8, 32'h0);
        check({31'b0, irq}, 32'h0, "R10 enables cleared");
        kb(8'h11);
        check({31'b0, irq}, 32'h1, "R10 rx ready+ie");
        // R5: overrun overwrites and keeps ready
        kb(8'h22);
        rd(BASE | 32'h0, 32'h3, "R5 overrun ready");
        rd(BASE | 32'h4, 32'h22, "R5 overrun data");
        check({31'b0, irq}, 32'h0, "R10 irq drops after read");
        // R5: arrival in the same cycle as a data read
        kb(8'h33);
        @(negedge clk);
        bus_addr = BASE | 32'h4; bus_re = 1'b1;
        kbd_char = 8'h44; kbd_valid = 1'b1;
        #1 check(bus_rdata, 32'h33, "R5 same-cycle old char");
        @(posedge clk); #1 begin bus_re = 1'b0; kbd_valid = 1'b0; end
        rd(BASE | 32'h0, 32'h3, "R5 same-cycle ready kept");
        rd(BASE | 32'h4, 32'h44, "R5 same-cycle new char");
        rd(BASE | 32'h0, 32'h2, "R4 cleared after read");
        // R9: bit 0 of a control write cannot set ready
        wr(BASE | 32'h0, 32'h1);
        rd(BASE | 32'h0, 32'h0, "R9 ready not writable");
        // R6 and R7: start a transfer, then write while busy
        wr(BASE | 32'hC, 32'h61);
        check({31'b0, disp_valid}, 32'h1, "R6 disp_valid");
        check({24'b0, disp_char}, 32'h61, "R6 disp_char");
        wr(BASE | 32'hC, 32'h62);
        check({24'b0, disp_char}, 32'h61, "R7 busy write ignored");
        rd(BASE | 32'hC, 32'h61, "R7 data unchanged");
        // R8
        ack();
        check({31'b0, disp_valid}, 32'h0, "R8 disp_valid dropped");
        rd(BASE | 32'h8, 32'h1, "R8 ready restored");
        // R11: outside the window
        wr(32'h0000_0008, 32'h2);
        rd(BASE | 32'h8, 32'h1, "R11 outside write no effect");
        rd(32'h0000_0008, 32'h0, "R11 outside read zero");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule